// File: doc/BRIEF.md
# Comparison-Window Timeout Supervisor

This block watches over one comparison window of a frequency comparator. Once started, it counts rising edges of a slow reference clock. If the configured number of reference edges arrives before the classifier has reported a result (fast, slow or in range), it raises a one-cycle error pulse. Any outcome, whether one of the three results or the error, produces a one-cycle completion pulse. The cycle after that, it produces a one-cycle restart pulse that the rest of the comparator uses to return to its starting state. The supervisor also clears its own window on that pulse, so supervision runs on without a break.

Bring-up is controlled by two active-low inputs. A low level on the initialization input, sampled at a clock edge, clears every register to zero. After initialization is released, a hold-off of a fixed number of clock cycles must pass. A falling edge on the run input after that hold-off arms the block. The reference clock and the run input are asynchronous, so each one passes through a multi-stage synchronizer and an edge detector in the system clock domain. The three result inputs come from logic that already runs on the system clock.

Top module: `freq_watchdog`

## Requirements
- R1: While `init_n` is low at a rising clock edge, all state is cleared: `err_pulse`, `done` and `restart` are 0 after that edge, the edge count is zero, and the block is unarmed until a new run start.
- R2: A falling edge of `run_n` arms the block only when it reaches the control logic at least `HOLD_CYC` clock edges after `init_n` was released. An earlier falling edge is ignored. While the block is unarmed, reference edges are not counted and result inputs produce no pulse.
- R3: `ref_lo` passes through `SYNC_STAGES` flops. Each low-to-high transition counts as exactly one edge, however long the high level lasts. An edge visible at the synchronizer output is processed at the following clock edge, so the count updates three clock edges after the input rises (default stages).
- R4: When the `TIMEOUT_EDGES`-th counted edge of a window is processed and no result is present in that cycle, `err_pulse` is 1 for exactly one cycle, in the same cycle as `done`. The count then holds at its terminal value until the window is cleared.
- R5: If a result is present in the cycle in which the terminal edge is processed, the result wins: `done` pulses and `err_pulse` stays 0.
- R6: A result (`res_fast`, `res_slow` or `res_ok` high) sampled at a clock edge while the block is armed and watching makes `done` 1 for exactly the following cycle.
- R7: `restart` is 1 for exactly one cycle, the cycle immediately after `done`. `done` and `restart` are never 1 together.
- R8: During the `done` and `restart` cycles, results and reference edges are ignored. The clock edge at which `restart` is 1 clears the count, so the next window again needs `TIMEOUT_EDGES` edges before an error.
- R9: A falling edge of `run_n` while the block is already armed has no effect on the count or on the outputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| init_n | input | 1 | Active-low initialization, sampled synchronously |
| run_n | input | 1 | Active-low run; a falling edge starts supervision |
| ref_lo | input | 1 | Low-frequency reference clock, asynchronous |
| res_fast | input | 1 | Classifier result: test frequency too high |
| res_slow | input | 1 | Classifier result: test frequency too low |
| res_ok | input | 1 | Classifier result: test frequency in range |
| err_pulse | output | 1 | One-cycle timeout error |
| done | output | 1 | One-cycle pulse on any outcome |
| restart | output | 1 | One-cycle restart pulse, the cycle after done |

## Verification
The bench builds the block with its default parameters: two synchronizer stages, an eight-edge timeout and a four-cycle hold-off. With these values the terminal count is reached within about fifty clock cycles. Many back-to-back windows can therefore be driven, including error windows followed at once by fresh windows. The short hold-off also means a run edge can be placed, to the exact cycle, just inside the hold-off. Reference pulses are only a few cycles long, so the cycle in which the terminal edge is processed can be lined up with a result.

// File: rtl/fwd_pkg.sv
package fwd_pkg;

    // Start sequencer states
    typedef enum logic [1:0] {
        SQ_HOLD   = 2'd0,
        SQ_READY  = 2'd1,
        SQ_ACTIVE = 2'd2
    } seq_state_e;

    // Outcome phases within one window
    typedef enum logic [1:0] {
        PH_WATCH   = 2'd0,
        PH_DONE    = 2'd1,
        PH_RESTART = 2'd2
    } phase_e;

    // Classifier result bundle
    typedef struct packed {
        logic fast;
        logic slow;
        logic ok;
    } result_t;

    // Outputs of the outcome stage
    typedef struct packed {
        logic err;
        logic done;
        logic restart;
        logic watching;
    } outcome_t;

    function automatic logic any_result(input result_t r);
        return r.fast | r.slow | r.ok;
    endfunction

    function automatic int unsigned cnt_width(input int unsigned n);
        return (n < 2) ? 1 : $clog2(n + 1);
    endfunction

endpackage

// File: rtl/fwd_sync.sv
module fwd_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk) begin
                if (rst) chain <= '0;
                else     chain <= d;
            end
        end else begin : g_multi
            always_ff @(posedge clk) begin
                if (rst) chain <= '0;
                else     chain <= {chain[STAGES-2:0], d};
            end
        end
    endgenerate

    assign q = chain[STAGES-1];
endmodule

// File: rtl/fwd_edge.sv
module fwd_edge #(
    parameter bit RISING = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic level,
    output logic hit
);
    logic prev;

    always_ff @(posedge clk) begin
        if (rst) prev <= 1'b0;
        else     prev <= level;
    end

    generate
        if (RISING) begin : g_rise
            assign hit = level & ~prev;
        end else begin : g_fall
            assign hit = ~level & prev;
        end
    endgenerate
endmodule

// File: rtl/fwd_seq.sv
module fwd_seq
    import fwd_pkg::*;
#(
    parameter int unsigned HOLD_CYC = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic run_fall,
    output logic active
);
    localparam int unsigned HOLD_W = cnt_width(HOLD_CYC);
    localparam logic [HOLD_W-1:0] HOLD_LAST = HOLD_W'(HOLD_CYC - 1);

    seq_state_e        state;
    logic [HOLD_W-1:0] hold_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= SQ_HOLD;
            hold_cnt <= '0;
        end else begin
            unique case (state)
                SQ_HOLD: begin
                    if (hold_cnt == HOLD_LAST) state <= SQ_READY;
                    else                       hold_cnt <= hold_cnt + 1'b1;
                end
                SQ_READY: begin
                    if (run_fall) state <= SQ_ACTIVE;
                end
                SQ_ACTIVE: state <= SQ_ACTIVE;
                default:   state <= SQ_HOLD;
            endcase
        end
    end

    assign active = (state == SQ_ACTIVE);
endmodule

// File: rtl/fwd_timeout.sv
module fwd_timeout
    import fwd_pkg::*;
#(
    parameter int unsigned EDGES = 8
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           clear,
    input  logic                           step,
    output logic [cnt_width(EDGES)-1:0]    cnt,
    output logic                           last
);
    localparam int unsigned CNT_W = cnt_width(EDGES);
    localparam logic [CNT_W-1:0] TERM     = CNT_W'(EDGES);
    localparam logic [CNT_W-1:0] PRE_TERM = CNT_W'(EDGES - 1);

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            cnt <= '0;
        end else if (step && (cnt != TERM)) begin
            cnt <= cnt + 1'b1;
        end
    end

    // The edge being processed now is the terminal one
    assign last = step && (cnt == PRE_TERM);
endmodule

// File: rtl/fwd_outcome.sv
module fwd_outcome
    import fwd_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     active,
    input  result_t  res,
    input  logic     last_edge,
    output outcome_t out
);
    phase_e phase;
    logic   err_q;
    logic   watching;
    logic   got_result;
    logic   expire;

    assign watching   = active && (phase == PH_WATCH);
    assign got_result = watching && any_result(res);
    assign expire     = watching && last_edge && !any_result(res);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= PH_WATCH;
            err_q <= 1'b0;
        end else begin
            err_q <= expire;
            unique case (phase)
                PH_WATCH:   if (got_result || expire) phase <= PH_DONE;
                PH_DONE:    phase <= PH_RESTART;
                PH_RESTART: phase <= PH_WATCH;
                default:    phase <= PH_WATCH;
            endcase
        end
    end

    assign out.err      = err_q;
    assign out.done     = (phase == PH_DONE);
    assign out.restart  = (phase == PH_RESTART);
    assign out.watching = watching;
endmodule

// File: rtl/freq_watchdog.sv
module freq_watchdog
    import fwd_pkg::*;
#(
    parameter int unsigned SYNC_STAGES   = 2,
    parameter int unsigned TIMEOUT_EDGES = 8,
    parameter int unsigned HOLD_CYC      = 4
) (
    input  logic clk,
    input  logic init_n,
    input  logic run_n,
    input  logic ref_lo,
    input  logic res_fast,
    input  logic res_slow,
    input  logic res_ok,
    output logic err_pulse,
    output logic done,
    output logic restart
);
    localparam int unsigned CNT_W   = cnt_width(TIMEOUT_EDGES);
    localparam int unsigned N_ASYNC = 2;

    logic               init_rst;
    logic [N_ASYNC-1:0] raw_in;
    logic [N_ASYNC-1:0] synced;
    logic [N_ASYNC-1:0] edge_hit;
    logic               ref_rise;
    logic               run_fall;
    logic               active;
    logic [CNT_W-1:0]   tmo_cnt;
    logic               tmo_last;
    result_t            res;
    outcome_t           oc;

    assign init_rst = ~init_n;
    assign raw_in   = {run_n, ref_lo};

    // Index 0: reference clock, rising edges; index 1: run, falling edges
    generate
        for (genvar i = 0; i < N_ASYNC; i++) begin : g_async
            fwd_sync #(.STAGES(SYNC_STAGES)) u_sync (
                .clk (clk),
                .rst (init_rst),
                .d   (raw_in[i]),
                .q   (synced[i])
            );
            fwd_edge #(.RISING(i == 0)) u_edge (
                .clk   (clk),
                .rst   (init_rst),
                .level (synced[i]),
                .hit   (edge_hit[i])
            );
        end
    endgenerate

    assign ref_rise = edge_hit[0];
    assign run_fall = edge_hit[1];

    fwd_seq #(.HOLD_CYC(HOLD_CYC)) u_seq (
        .clk      (clk),
        .rst      (init_rst),
        .run_fall (run_fall),
        .active   (active)
    );

    fwd_timeout #(.EDGES(TIMEOUT_EDGES)) u_tmo (
        .clk   (clk),
        .rst   (init_rst),
        .clear (oc.restart),
        .step  (oc.watching && ref_rise),
        .cnt   (tmo_cnt),
        .last  (tmo_last)
    );

    assign res = '{fast: res_fast, slow: res_slow, ok: res_ok};

    fwd_outcome u_oc (
        .clk       (clk),
        .rst       (init_rst),
        .active    (active),
        .res       (res),
        .last_edge (tmo_last),
        .out       (oc)
    );

    assign err_pulse = oc.err;
    assign done      = oc.done;
    assign restart   = oc.restart;
endmodule

// File: rtl/fwd_checker.sv
module fwd_checker #(
    parameter int unsigned EDGES = 8,
    parameter int unsigned CNT_W = 4
) (
    input logic             clk,
    input logic             rst,
    input logic             active,
    input logic             err,
    input logic             done,
    input logic             restart,
    input logic [CNT_W-1:0] cnt
);
    a_r7_restart_follows_done: assert property (@(posedge clk) disable iff (rst)
        done |=> restart);

    a_r7_restart_single: assert property (@(posedge clk) disable iff (rst)
        restart |=> !restart);

    a_r7_no_overlap: assert property (@(posedge clk) disable iff (rst)
        !(done && restart));

    a_r6_done_single: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    a_r4_err_with_done: assert property (@(posedge clk) disable iff (rst)
        err |-> done);

    a_r4_cnt_bounded: assert property (@(posedge clk) disable iff (rst)
        cnt <= CNT_W'(EDGES));

    a_r2_unarmed_quiet: assert property (@(posedge clk) disable iff (rst)
        !active |-> (!done && !err && cnt == '0));

    a_r8_restart_clears: assert property (@(posedge clk) disable iff (rst)
        restart |=> (cnt == '0));
endmodule

bind freq_watchdog fwd_checker #(
    .EDGES (TIMEOUT_EDGES),
    .CNT_W (CNT_W)
) u_chk (
    .clk     (clk),
    .rst     (init_rst),
    .active  (active),
    .err     (err_pulse),
    .done    (done),
    .restart (restart),
    .cnt     (tmo_cnt)
);

// File: tb/sim_freq_watchdog.sv
module sim_freq_watchdog;
    localparam int unsigned EDGES = 8;
    localparam int unsigned HOLD  = 4;

    logic clk = 1'b0;
    logic init_n = 1'b0, run_n = 1'b1, ref_lo = 1'b0;
    logic res_fast = 1'b0, res_slow = 1'b0, res_ok = 1'b0;
    logic err_pulse, done, restart;

    int n_chk = 0, n_fail = 0;
    int n_err = 0, n_done = 0, n_rs = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    freq_watchdog #(.SYNC_STAGES(2), .TIMEOUT_EDGES(EDGES), .HOLD_CYC(HOLD)) u0 (
        .clk(clk), .init_n(init_n), .run_n(run_n), .ref_lo(ref_lo),
        .res_fast(res_fast), .res_slow(res_slow), .res_ok(res_ok),
        .err_pulse(err_pulse), .done(done), .restart(restart)
    );

    always @(negedge clk) begin
        if (err_pulse === 1'b1) n_err++;
        if (done === 1'b1)      n_done++;
        if (restart === 1'b1)   n_rs++;
    end

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic chk(input bit good, input string tag, input int act, input int exp);
        n_chk++;
        if (!good) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int exp_errors(input int edges_seen);
        return (edges_seen >= int'(EDGES)) ? 1 : 0;
    endfunction

    task automatic ref_pulse(input int hi);
        ref_lo = 1'b1;
        repeat (hi) tick();
        ref_lo = 1'b0;
        repeat (3) tick();
    endtask

    task automatic pulses(input int n);
        for (int i = 0; i < n; i++) ref_pulse(3);
    endtask

    task automatic give_result(input int kind, input int len);
        res_fast = (kind == 0);
        res_slow = (kind == 1);
        res_ok   = (kind == 2);
        repeat (len) tick();
        res_fast = 1'b0; res_slow = 1'b0; res_ok = 1'b0;
    endtask

    task automatic do_run();
        run_n = 1'b0;
        repeat (4) tick();
        run_n = 1'b1;
        repeat (4) tick();
    endtask

    task automatic do_init();
        init_n = 1'b0;
        repeat (5) tick();
        #1;
        chk(err_pulse == 0 && done == 0 && restart == 0, "R1 outputs cleared by init",
            {err_pulse, done, restart}, 0);
        init_n = 1'b1;
    endtask

    // Compare outcome counters accumulated since a snapshot
    task automatic window_check(input string tag, input int e0, input int d0, input int r0,
                                input int exp_e, input int exp_d);
        repeat (4) tick();
        #1;
        chk(n_err - e0 == exp_e, {tag, " errors"}, n_err - e0, exp_e);
        chk(n_done - d0 == exp_d, {tag, " done pulses"}, n_done - d0, exp_d);
        chk(n_rs - r0 == exp_d, {tag, " restart pulses"}, n_rs - r0, exp_d);
    endtask

    initial begin
        int e0, d0, r0;
        void'($urandom(32'd4242));

        // R1: reset state
        tick();
        do_init();

        // R2: run edge inside hold-off is ignored
        tick();
        run_n = 1'b0;
        repeat (3) tick();
        run_n = 1'b1;
        tick(); #1;
        e0 = n_err; d0 = n_done; r0 = n_rs;
        give_result(2, 1);
        pulses(10);
        window_check("R2 unarmed after early run", e0, d0, r0, 0, 0);

        // R2: proper start after hold-off
        repeat (6) tick();
        do_run();

        // R6/R7: exact latency of done and restart
        res_fast = 1'b1;
        tick();
        res_fast = 1'b0;
        #1;
        chk(done == 1 && restart == 0, "R6 done one cycle after result", {done, restart}, 2);
        tick(); #1;
        chk(done == 0 && restart == 1, "R7 restart right after done", {done, restart}, 1);
        tick(); #1;
        chk(done == 0 && restart == 0, "R7 restart one cycle wide", {done, restart}, 0);

        // R8: result held during done/restart gives one outcome
        e0 = n_err; d0 = n_done; r0 = n_rs;
        give_result(2, 3);
        window_check("R8 held result single outcome", e0, d0, r0, 0, 1);

        // R4: seven edges no error, eighth edge errors with exact timing
        e0 = n_err; d0 = n_done; r0 = n_rs;
        pulses(EDGES - 1);
        #1;
        chk(n_err == e0 && n_done == d0, "R4 no error before terminal edge", n_err - e0, 0);
        ref_lo = 1'b1;
        tick(); tick(); tick(); #1;
        chk(err_pulse == 1 && done == 1, "R4 error with done at terminal edge",
            {err_pulse, done}, 3);
        tick(); #1;
        chk(err_pulse == 0 && restart == 1, "R4 error single cycle, R7 restart",
            {err_pulse, restart}, 1);
        ref_lo = 1'b0;
        repeat (3) tick();

        // R8: new window counts from zero after restart
        e0 = n_err; d0 = n_done; r0 = n_rs;
        pulses(EDGES - 1);
        window_check("R8 fresh window below terminal", e0, d0, r0, 0, 0);
        pulses(1);
        window_check("R8 fresh window terminal", e0, d0, r0, 1, 1);

        // R5: result in the same cycle as the terminal edge
        e0 = n_err; d0 = n_done; r0 = n_rs;
        pulses(EDGES - 1);
        ref_lo = 1'b1;
        tick(); tick();
        res_ok = 1'b1;
        tick();
        res_ok = 1'b0;
        #1;
        chk(done == 1 && err_pulse == 0, "R5 result wins tie", {done, err_pulse}, 2);
        ref_lo = 1'b0;
        repeat (3) tick();
        window_check("R5 tie window", e0, d0, r0, 0, 1);

        // R9: run edge while armed does not clear the count
        e0 = n_err; d0 = n_done; r0 = n_rs;
        pulses(5);
        do_run();
        pulses(EDGES - 5);
        window_check("R9 run while armed ignored", e0, d0, r0, 1, 1);

        // R3: a long high level counts as one edge
        e0 = n_err; d0 = n_done; r0 = n_rs;
        pulses(EDGES - 2);
        ref_pulse(20);
        window_check("R3 long pulse counted once", e0, d0, r0, 0, 0);
        pulses(1);
        window_check("R3 terminal after long pulse", e0, d0, r0, 1, 1);

        // R1: init in mid-window clears count and disarms
        pulses(5);
        do_init();
        repeat (HOLD + 4) tick();
        e0 = n_err; d0 = n_done; r0 = n_rs;
        give_result(0, 1);
        window_check("R1 disarmed after init", e0, d0, r0, 0, 0);
        do_run();
        e0 = n_err; d0 = n_done; r0 = n_rs;
        pulses(EDGES - 1);
        window_check("R1 count cleared by init", e0, d0, r0, 0, 0);
        pulses(1);
        window_check("R1 terminal after re-init", e0, d0, r0, 1, 1);

        // Random windows (R4, R6)
        for (int w = 0; w < 30; w++) begin
            int k;
            int n;
            k = $urandom_range(0, EDGES + 1);
            n = (k >= int'(EDGES)) ? int'(EDGES) : k;
            e0 = n_err; d0 = n_done; r0 = n_rs;
            pulses(n);
            if (k < int'(EDGES)) give_result($urandom_range(0, 2), 1);
            window_check($sformatf("R4 R6 random window %0d k=%0d", w, k),
                         e0, d0, r0, exp_errors(k), 1);
        end

        finished = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #1500000;
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule